// File: doc/BRIEF.md
# Shift and Logic Execution Unit

This block is the data path of a small register machine's execute stage. Each cycle it takes a 5-bit operation code, two 32-bit source operands, a 5-bit shift count and a 20-bit immediate. It forms the result of one shift, logic or add/subtract operation and four status bits: negative, zero, positive and carry-out. Result and status pass through one register stage. The surrounding pipeline samples them on the clock edge that follows the edge where the operands were presented.

The shift group uses the first source and the count. There is no rotate-right code. A right rotate by N is requested as a left rotate by 32 minus N. The immediate forms combine the first source with the immediate. The logical immediate form widens the immediate with zeros. The additive immediate form widens it with its sign bit. A subtract whose result is thrown away acts as a compare, because the status bits still reflect the difference.

Top module: `sla_exec_unit`

## Requirements
- R1: Code 10000 shifts src1_i left by shamt_i and fills the vacated low bits with zeros.
- R2: Code 10001 rotates src1_i left by shamt_i. Bits leaving the top re-enter at the bottom.
- R3: Code 10010 shifts src1_i right by shamt_i with zero fill. Code 10011 shifts it right with copies of bit 31 as the fill.
- R4: For any of the four shift codes, a shamt_i of 0 returns src1_i unchanged.
- R5: Code 10100 returns the bitwise inverse of src1_i. Its result does not depend on shamt_i or src2_i.
- R6: Code 10101 returns src1_i + src2_i modulo 2^32. carry_o is the carry out of bit 31.
- R7: Code 10110 returns src1_i - src2_i. carry_o is the carry out of src1_i + ~src2_i + 1, so equal operands give zero_o = 1 and carry_o = 1.
- R8: Codes 10111, 11000 and 11001 return the bitwise AND, OR and XOR of src1_i and src2_i.
- R9: Code 00010 returns src1_i AND the immediate widened to 32 bits with zeros in bits 31..20.
- R10: Code 00011 returns src1_i plus the immediate sign-extended from bit 19. carry_o is the carry out of bit 31 of that sum.
- R11: For every listed code, neg_o equals result bit 31 and zero_o is set exactly when the result is all zeros. pos_o is set when neither of those is set. carry_o is 0 for the shift and logic codes.
- R12: Any code not listed in R1 to R10 gives a zero result with all four status bits low.
- R13: Outputs change one clock after the inputs are sampled. While rst_n is low, the result and all status bits are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| src1_i | input | 32 | First source operand (also the shifted value) |
| src2_i | input | 32 | Second source operand |
| shamt_i | input | 5 | Unsigned shift count, 0 to 31 |
| imm_i | input | 20 | Immediate operand |
| result_o | output | 32 | Registered result |
| neg_o | output | 1 | Result is negative |
| zero_o | output | 1 | Result is zero |
| pos_o | output | 1 | Result is positive and non-zero |
| carry_o | output | 1 | Carry-out of the adder operations |

## Verification
The case hardest to reach from the ports is where fill policy and count interact at the extremes. Examples are an arithmetic right shift of a negative value by 31 and a rotate by 31 that must equal a rotate right by 1. Another is the carry of a subtract with equal or all-ones operands. Random operands almost never hit these, so the stimulus first drives them as directed vectors: sign-bit-only values, all ones, counts 0, 1, 16 and 31, and immediates with bit 19 set and clear. A long random run then follows, spread over every 5-bit code including the unlisted ones. It is checked against a behavioural model on every clock.

// File: rtl/sla_pkg.sv
package sla_pkg;

    localparam int unsigned OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ANDI = 5'b00010,
        OP_ADDI = 5'b00011,
        OP_SHL  = 5'b10000,
        OP_ROL  = 5'b10001,
        OP_SHR  = 5'b10010,
        OP_SAR  = 5'b10011,
        OP_INV  = 5'b10100,
        OP_ADD  = 5'b10101,
        OP_SUB  = 5'b10110,
        OP_AND  = 5'b10111,
        OP_OR   = 5'b11000,
        OP_XOR  = 5'b11001
    } sla_op_e;

    // Order matches the low two bits of the shift codes.
    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_RL = 2'd1,
        SH_LR = 2'd2,
        SH_AR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_INV = 2'd3
    } logic_kind_e;

endpackage

// File: rtl/sla_shifter.sv
module sla_shifter
    import sla_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
    input  shift_kind_e          kind_i,
    input  logic [DATA_W-1:0]    din_i,
    input  logic [SHAMT_W-1:0]   shamt_i,
    output logic [DATA_W-1:0]    dout_o
);

    logic [DATA_W-1:0] stage [SHAMT_W+1];

    assign stage[0] = din_i;

    // One stage per count bit; stage k moves by 2**k when that bit is set.
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
        localparam int unsigned DIST = 1 << k;
        logic [DATA_W-1:0] cur;
        logic [DATA_W-1:0] moved;
        logic [DATA_W-1:0] nxt;

        assign cur = stage[k];

        always_comb begin
            unique case (kind_i)
                SH_LL:   moved = cur << DIST;
                SH_RL:   moved = {cur[DATA_W-DIST-1:0], cur[DATA_W-1:DATA_W-DIST]};
                SH_LR:   moved = cur >> DIST;
                SH_AR:   moved = $signed(cur) >>> DIST;
                default: moved = cur;
            endcase
            nxt = shamt_i[k] ? moved : cur;
        end

        assign stage[k+1] = nxt;
    end

    assign dout_o = stage[SHAMT_W];

    // R4: a zero count leaves the operand untouched for every kind.
    always_comb begin
        if (shamt_i == '0) begin
            p_pass_zero_count_r4: assert (dout_o == din_i);
        end
    end

endmodule

// File: rtl/sla_adder.sv
module sla_adder #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   total;

    assign b_eff = sub_i ? ~b_i : b_i;
    assign total = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};

    assign sum_o  = total[DATA_W-1:0];
    assign cout_o = total[DATA_W];

endmodule

// File: rtl/sla_logic.sv
module sla_logic
    import sla_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic_kind_e       kind_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] dout_o
);

    always_comb begin
        unique case (kind_i)
            LG_AND:  dout_o = a_i & b_i;
            LG_OR:   dout_o = a_i | b_i;
            LG_XOR:  dout_o = a_i ^ b_i;
            LG_INV:  dout_o = ~a_i;
            default: dout_o = '0;
        endcase
    end

endmodule

// File: rtl/sla_exec_unit.sv
module sla_exec_unit
    import sla_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [4:0]                   op_i,
    input  logic [DATA_W-1:0]            src1_i,
    input  logic [DATA_W-1:0]            src2_i,
    input  logic [$clog2(DATA_W)-1:0]    shamt_i,
    input  logic [IMM_W-1:0]             imm_i,
    output logic [DATA_W-1:0]            result_o,
    output logic                         neg_o,
    output logic                         zero_o,
    output logic                         pos_o,
    output logic                         carry_o
);

    localparam int unsigned SHAMT_W = $clog2(DATA_W);
    localparam int unsigned EXT_W   = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              neg;
        logic              zero;
        logic              pos;
        logic              carry;
    } exec_state_t;

    exec_state_t st_d, st_q;

    logic [DATA_W-1:0] imm_zx, imm_sx;
    logic [DATA_W-1:0] sh_out, lg_out, add_out, add_b, lg_b;
    logic              add_cout, add_sub;
    shift_kind_e       sh_kind;
    logic_kind_e       lg_kind;

    function automatic logic op_known(input logic [4:0] o);
        case (o)
            OP_ANDI, OP_ADDI, OP_SHL, OP_ROL, OP_SHR, OP_SAR,
            OP_INV, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    assign imm_zx = {{EXT_W{1'b0}}, imm_i};
    assign imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

    // Shift kind is the low two code bits of the shift group.
    assign sh_kind = shift_kind_e'(op_i[1:0]);

    always_comb begin
        unique case (op_i)
            OP_OR:   lg_kind = LG_OR;
            OP_XOR:  lg_kind = LG_XOR;
            OP_INV:  lg_kind = LG_INV;
            default: lg_kind = LG_AND;
        endcase
    end

    assign lg_b    = (op_i == OP_ANDI) ? imm_zx : src2_i;
    assign add_b   = (op_i == OP_ADDI) ? imm_sx : src2_i;
    assign add_sub = (op_i == OP_SUB);

    sla_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .kind_i  (sh_kind),
        .din_i   (src1_i),
        .shamt_i (shamt_i),
        .dout_o  (sh_out)
    );

    sla_logic #(.DATA_W(DATA_W)) u_logic (
        .kind_i (lg_kind),
        .a_i    (src1_i),
        .b_i    (lg_b),
        .dout_o (lg_out)
    );

    sla_adder #(.DATA_W(DATA_W)) u_add (
        .a_i    (src1_i),
        .b_i    (add_b),
        .sub_i  (add_sub),
        .sum_o  (add_out),
        .cout_o (add_cout)
    );

    always_comb begin
        logic valid;
        st_d  = '0;
        valid = 1'b1;
        unique case (op_i)
            OP_SHL, OP_ROL, OP_SHR, OP_SAR: st_d.res = sh_out;
            OP_INV, OP_AND, OP_OR, OP_XOR, OP_ANDI: st_d.res = lg_out;
            OP_ADD, OP_SUB, OP_ADDI: begin
                st_d.res   = add_out;
                st_d.carry = add_cout;
            end
            default: valid = 1'b0;
        endcase
        if (valid) begin
            st_d.neg  = st_d.res[DATA_W-1];
            st_d.zero = (st_d.res == '0);
            st_d.pos  = !st_d.neg && !st_d.zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign neg_o    = st_q.neg;
    assign zero_o   = st_q.zero;
    assign pos_o    = st_q.pos;
    assign carry_o  = st_q.carry;

    // R11: sign flag tracks the top result bit.
    p_neg_is_msb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        neg_o == result_o[DATA_W-1]);

    // R11: zero flag only with an all-zero result.
    p_zero_means_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (result_o == '0));

    // R11: positive excludes the other two.
    p_pos_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o |-> (!neg_o && !zero_o && result_o != '0));

    // R11: carry only from the adder codes.
    p_carry_scope_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_i == OP_ADD || op_i == OP_SUB || op_i == OP_ADDI) |=> !carry_o);

    // R12: unlisted codes give an empty result.
    p_unknown_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_known(op_i) |=> (result_o == '0 && !neg_o && !zero_o && !pos_o && !carry_o));

    // R5: inversion of the first source.
    p_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INV) |=> (result_o == ~$past(src1_i)));

    // R7: compare of equal values.
    p_sub_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SUB && src1_i == src2_i) |=> (zero_o && carry_o));

endmodule

// File: tb/tb_sla_exec_unit.sv
`timescale 1ns/1ps
module tb_sla_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] s1 = '0, s2 = '0;
    logic [4:0]  sh = '0;
    logic [19:0] imm = '0;
    logic [31:0] result;
    logic        neg, zero, pos, carry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        pend = 1'b0;
    logic [31:0] exp_r;
    logic        exp_n, exp_z, exp_p, exp_c;
    string       exp_tag;

    always #4 clk = ~clk;

    sla_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .src1_i(s1), .src2_i(s2),
        .shamt_i(sh), .imm_i(imm), .result_o(result), .neg_o(neg),
        .zero_o(zero), .pos_o(pos), .carry_o(carry)
    );

    task automatic model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] n, input logic [19:0] im);
        logic [32:0] wide;
        logic [31:0] r;
        logic        c, ok;
        string       t;
        r = '0; c = 1'b0; ok = 1'b1; t = "R12";
        case (o)
            5'b10000: begin r = a; for (int i = 0; i < n; i++) r = {r[30:0], 1'b0}; t = "R1"; end
            5'b10001: begin r = a; for (int i = 0; i < n; i++) r = {r[30:0], r[31]}; t = "R2"; end
            5'b10010: begin r = a; for (int i = 0; i < n; i++) r = {1'b0, r[31:1]}; t = "R3"; end
            5'b10011: begin r = a; for (int i = 0; i < n; i++) r = {r[31], r[31:1]}; t = "R3"; end
            5'b10100: begin r = ~a; t = "R5"; end
            5'b10101: begin wide = {1'b0, a} + {1'b0, b}; r = wide[31:0]; c = wide[32]; t = "R6"; end
            5'b10110: begin wide = {1'b0, a} + {1'b0, ~b} + 33'd1; r = wide[31:0]; c = wide[32]; t = "R7"; end
            5'b10111: begin r = a & b; t = "R8"; end
            5'b11000: begin r = a | b; t = "R8"; end
            5'b11001: begin r = a ^ b; t = "R8"; end
            5'b00010: begin r = a & {12'h000, im}; t = "R9"; end
            5'b00011: begin
                wide = {1'b0, a} + {1'b0, {{12{im[19]}}, im}};
                r = wide[31:0]; c = wide[32]; t = "R10";
            end
            default: ok = 1'b0;
        endcase
        if (ok && o[4:2] == 3'b100 && n == 5'd0) t = "R4";
        exp_r = r; exp_c = c; exp_tag = t;
        exp_n = ok && r[31];
        exp_z = ok && (r == 32'd0);
        exp_p = ok && !r[31] && (r != 32'd0);
    endtask

    task automatic compare_pending();
        if (pend) begin
            checks++;
            if (result !== exp_r || neg !== exp_n || zero !== exp_z || pos !== exp_p || carry !== exp_c) begin
                errors++;
                $display("FAIL %s (status per R11) actual r=%h nzpc=%b%b%b%b expected r=%h nzpc=%b%b%b%b",
                         exp_tag, result, neg, zero, pos, carry, exp_r, exp_n, exp_z, exp_p, exp_c);
            end
        end
    endtask

    task automatic apply(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] n, input logic [19:0] im);
        @(negedge clk);
        compare_pending();
        op = o; s1 = a; s2 = b; sh = n; imm = im;
        model(o, a, b, n, im);
        pend = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (actual running, expected done)");
        finish_run();
    end

    logic [4:0] valid_ops [12] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10100, 5'b10101,
                                   5'b10110, 5'b10111, 5'b11000, 5'b11001, 5'b00010, 5'b00011};

    initial begin
        // R13: outputs stay cleared during reset even with live inputs.
        op = 5'b10100; s1 = 32'h0000_0000;
        repeat (3) @(negedge clk);
        checks++;
        if (result !== 32'd0 || neg || zero || pos || carry) begin
            errors++;
            $display("FAIL R13 reset actual r=%h nzpc=%b%b%b%b expected r=00000000 nzpc=0000",
                     result, neg, zero, pos, carry);
        end
        rst_n = 1'b1;

        // Directed corners.
        apply(5'b10000, 32'h8000_0001, 0, 5'd1, 0);          // R1
        apply(5'b10000, 32'hFFFF_FFFF, 0, 5'd31, 0);         // R1
        apply(5'b10001, 32'h8000_0001, 0, 5'd31, 0);         // R2: rotate right by 1
        apply(5'b10001, 32'h1234_5678, 0, 5'd16, 0);         // R2
        apply(5'b10010, 32'h8000_0000, 0, 5'd31, 0);         // R3
        apply(5'b10011, 32'h8000_0000, 0, 5'd31, 0);         // R3 all ones
        apply(5'b10011, 32'h7000_0000, 0, 5'd4, 0);          // R3 positive
        apply(5'b10000, 32'hDEAD_BEEF, 0, 5'd0, 0);          // R4
        apply(5'b10011, 32'h8000_0000, 0, 5'd0, 0);          // R4
        apply(5'b10100, 32'h0F0F_0000, 32'hFFFF, 5'd7, 0);   // R5
        apply(5'b10100, 32'hFFFF_FFFF, 32'h1, 5'd31, 0);     // R5 zero result
        apply(5'b10101, 32'hFFFF_FFFF, 32'h1, 0, 0);         // R6 carry, zero
        apply(5'b10101, 32'h7FFF_FFFF, 32'h1, 0, 0);         // R6 negative
        apply(5'b10110, 32'h1234_5678, 32'h1234_5678, 0, 0); // R7 equal
        apply(5'b10110, 32'h0, 32'h1, 0, 0);                 // R7 borrow
        apply(5'b10111, 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 0); // R8
        apply(5'b11000, 32'hF0F0_F0F0, 32'h0F0F_0000, 0, 0); // R8
        apply(5'b11001, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 0); // R8
        apply(5'b00010, 32'h7777_7777, 0, 0, 20'hFFA08);     // R9
        apply(5'b00010, 32'hFFFF_FFFF, 0, 0, 20'h80000);     // R9 no extension
        apply(5'b00011, 32'h0000_0005, 0, 0, 20'hFFFFF);     // R10 minus one
        apply(5'b00011, 32'h0000_0000, 0, 0, 20'h80000);     // R10 negative
        apply(5'b00011, 32'h1000_0000, 0, 0, 20'h7FFFF);     // R10 positive
        apply(5'b00000, 32'hFFFF_FFFF, 32'h1, 5'd3, 20'h1);  // R12
        apply(5'b11111, 32'h1, 32'h1, 5'd1, 20'h1);          // R12
        apply(5'b01100, 32'h8000_0000, 32'h0, 5'd0, 20'h0);  // R12

        // Random sweep over every code.
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] o;
            if (($urandom % 5) == 0) o = 5'($urandom);
            else o = valid_ops[$urandom % 12];
            apply(o, $urandom, $urandom, 5'($urandom), 20'($urandom));
        end

        @(negedge clk);
        compare_pending();
        pend = 1'b0;
        finish_run();
    end

endmodule